// File: doc/BRIEF.md
# Sector Test Pattern Generator and Checker

This block produces a 32-bit test stream for a storage data path, one 512-byte sector (128 words) at a time, and pushes it into a write FIFO. The same generator also serves as a reference for a read FIFO stream: each word that comes back is compared against the word the generator would have sent for that position, so one engine covers both directions of a disk write/read test.

Every sector opens with a two-word header that holds its own sector address. The header is followed by 126 payload words in one of five selectable patterns. The patterns include a 32-bit LFSR that is re-seeded from the sector address at every sector. This makes the data of every sector distinct. The engine latches the direction, the start sector, the sector count and the pattern on a start pulse. It runs until the programmed number of words has been moved, and it throttles itself on FIFO almost-full or empty. On the first read mismatch it records the byte address, the expected word and the received word.

Top module: `sector_pattern_engine`

## Requirements
- R1: A start pulse while idle, with a nonzero sector count, raises busy. Busy stays high until sectorCount*128 words have been accepted and then falls. With a zero count, busy stays low.
- R2: In write mode (dirRead=0 at start), wrEn is high exactly when busy is high and wrAlmostFull is low. While wrEn is low the word on wrData is held for the next accepted cycle, so no word is lost or repeated.
- R3: wordCount starts at 0 and increments by one on every accepted word (a cycle with wrEn or rdEn high). It ends at sectorCount*128.
- R4: In read mode (dirRead=1 at start), rdEn is high exactly when busy is high and rdEmpty is low.
- R5: Word index 0 of a sector carries bits [31:0] of the sector address. Word index 1 carries bits [63:32] of the address, zero-extended. The sector address starts at startSector and increases by one after word index 127.
- R6: For words 2..127, patternSel 0 gives {sector address[24:0], word index[6:0]}. Code 1 gives the bitwise inverse of code 0, code 2 gives all zeros and code 3 gives all ones. Codes 5 to 7 also give all zeros.
- R7: patternSel 4 gives an LFSR stream. Word 2 equals sector address[31:0], and each later word in the sector is next(q) = {q[30:0], q[30]^q[20]^q[0]} of the word before it. The polynomial is x^31+x^21+x+1.
- R8: In read mode, an accepted word that differs from the expected word sets failFlag. failFlag stays set until the next accepted start.
- R9: On the first mismatch only, the block captures three values and holds them: failByteAddr = sector*512 + index*4, failExpected and failReceived. Later mismatches do not change them.
- R10: A start pulse while busy is ignored: the stream, the count and the latched settings continue unchanged.
- R11: An accepted start clears failFlag, the three captured values and wordCount. This holds even when the sector count is zero.
- R12: After reset, busy, wrEn, rdEn, failFlag and wordCount are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle start request |
| dirRead | input | 1 | Direction latched at start: 0 write, 1 read/check |
| startSector | input | ADDR_W | First sector address |
| sectorCount | input | LEN_W | Number of sectors to move |
| patternSel | input | 3 | Payload pattern code |
| wrAlmostFull | input | 1 | Write FIFO almost full |
| wrEn | output | 1 | Write FIFO write enable |
| wrData | output | 32 | Generated word |
| rdEmpty | input | 1 | Read FIFO empty |
| rdData | input | 32 | Word read from the FIFO |
| rdEn | output | 1 | Read FIFO read enable |
| busy | output | 1 | Transfer in progress |
| wordCount | output | LEN_W+7 | Words moved since the last start |
| failFlag | output | 1 | Sticky mismatch flag |
| failByteAddr | output | ADDR_W+9 | Byte address of the first mismatch |
| failExpected | output | 32 | Expected word at the first mismatch |
| failReceived | output | 32 | Received word at the first mismatch |

## Verification
A wrong word counter or sector address shows on wrData within one accepted word: the header or payload at that position no longer matches the bench model. It also shows at the end of a transfer, when busy falls early or late and wordCount differs from sectorCount*128. A wrong LFSR state corrupts the next LFSR payload word. A stale seed is caught at word 2 of the next sector. Errors in the capture logic show after the transfer, either as a wrong failByteAddr or as captured values that moved on a second, injected mismatch.

// File: rtl/spe_pkg.sv
package spe_pkg;
  localparam int WORD_W       = 32;
  localparam int SECTOR_WORDS = 128;
  localparam int IDX_W        = $clog2(SECTOR_WORDS);
  localparam int HDR_W        = 2 * WORD_W;

  typedef enum logic [2:0] {
    PAT_INC  = 3'd0,
    PAT_DEC  = 3'd1,
    PAT_ZERO = 3'd2,
    PAT_ONE  = 3'd3,
    PAT_LFSR = 3'd4
  } pat_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;        // accepted start
    logic             checkEn;     // read word accepted, compare
    logic             payloadStep; // accepted word with index in 2..126
    logic             sectorEnd;   // accepted last word of a sector
    logic [IDX_W-1:0] wordIdx;     // word position inside the sector
  } spe_strobe_t;

  function automatic logic [WORD_W-1:0] lfsrNext(input logic [WORD_W-1:0] q);
    return {q[WORD_W-2:0], q[30] ^ q[20] ^ q[0]};
  endfunction
endpackage

// File: rtl/spe_ctrl.sv
module spe_ctrl
  import spe_pkg::*;
#(
  parameter int LEN_W = 32,
  localparam int CNT_W = LEN_W + IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             dirRead,
  input  logic [LEN_W-1:0] sectorCount,
  input  logic             wrAlmostFull,
  input  logic             rdEmpty,
  output logic             wrEn,
  output logic             rdEn,
  output logic             busy,
  output logic [CNT_W-1:0] wordCount,
  output spe_strobe_t      strb
);
  logic             active;
  logic             isRead;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] endCnt;
  logic [CNT_W-1:0] cntInc;
  logic             step;
  logic [IDX_W-1:0] idx;

  assign wrEn   = active & ~isRead & ~wrAlmostFull;
  assign rdEn   = active &  isRead & ~rdEmpty;
  assign step   = wrEn | rdEn;
  assign idx    = cnt[IDX_W-1:0];
  assign cntInc = cnt + {{(CNT_W-1){1'b0}}, 1'b1};

  always_comb begin
    strb.load        = startPulse & ~active;
    strb.checkEn     = rdEn;
    strb.sectorEnd   = step & (idx == {IDX_W{1'b1}});
    strb.payloadStep = step & (idx >= IDX_W'(2)) & (idx != {IDX_W{1'b1}});
    strb.wordIdx     = idx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      isRead <= 1'b0;
      cnt    <= '0;
      endCnt <= '0;
    end else if (startPulse && !active) begin
      active <= |sectorCount;
      isRead <= dirRead;
      cnt    <= '0;
      endCnt <= {sectorCount, {IDX_W{1'b0}}};
    end else if (step) begin
      cnt <= cntInc;
      if (cntInc == endCnt) active <= 1'b0;
    end
  end

  assign busy      = active;
  assign wordCount = cnt;
endmodule

// File: rtl/spe_datapath.sv
module spe_datapath
  import spe_pkg::*;
#(
  parameter int ADDR_W = 48,
  localparam int BADDR_W = ADDR_W + IDX_W + 2,
  localparam int INC_HI  = WORD_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  spe_strobe_t       strb,
  input  logic [ADDR_W-1:0] startSector,
  input  logic [2:0]        patternSel,
  input  logic [WORD_W-1:0] rdData,
  output logic [WORD_W-1:0] genWord,
  output logic              failFlag,
  output logic [BADDR_W-1:0] failByteAddr,
  output logic [WORD_W-1:0] failExpected,
  output logic [WORD_W-1:0] failReceived
);
  logic [ADDR_W-1:0] sectorAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic [WORD_W-1:0] lfsr;
  logic [2:0]        pattSel;
  logic [HDR_W-1:0]  hdr;
  logic [WORD_W-1:0] incWord;
  logic [WORD_W-1:0] payload;
  logic              mismatch;

  assign nextAddr = sectorAddr + {{(ADDR_W-1){1'b0}}, 1'b1};
  assign hdr      = HDR_W'(sectorAddr);
  assign incWord  = {sectorAddr[INC_HI-1:0], strb.wordIdx};

  always_comb begin
    case (pattSel)
      PAT_INC:  payload = incWord;
      PAT_DEC:  payload = ~incWord;
      PAT_ONE:  payload = {WORD_W{1'b1}};
      PAT_LFSR: payload = lfsr;
      default:  payload = '0;
    endcase
    if (strb.wordIdx == IDX_W'(0))      genWord = hdr[WORD_W-1:0];
    else if (strb.wordIdx == IDX_W'(1)) genWord = hdr[HDR_W-1:WORD_W];
    else                                genWord = payload;
  end

  assign mismatch = strb.checkEn & (rdData != genWord);

  // sector address, pattern state and latched select
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sectorAddr <= '0;
      lfsr       <= '0;
      pattSel    <= '0;
    end else if (strb.load) begin
      sectorAddr <= startSector;
      lfsr       <= startSector[WORD_W-1:0];
      pattSel    <= patternSel;
    end else if (strb.sectorEnd) begin
      sectorAddr <= nextAddr;
      lfsr       <= nextAddr[WORD_W-1:0];
    end else if (strb.payloadStep) begin
      lfsr <= lfsrNext(lfsr);
    end
  end

  // sticky flag and first-failure capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      failFlag     <= 1'b0;
      failByteAddr <= '0;
      failExpected <= '0;
      failReceived <= '0;
    end else if (strb.load) begin
      failFlag     <= 1'b0;
      failByteAddr <= '0;
      failExpected <= '0;
      failReceived <= '0;
    end else if (mismatch) begin
      failFlag <= 1'b1;
      if (!failFlag) begin
        failByteAddr <= {sectorAddr, strb.wordIdx, 2'b00};
        failExpected <= genWord;
        failReceived <= rdData;
      end
    end
  end
endmodule

// File: rtl/sector_pattern_engine.sv
module sector_pattern_engine
  import spe_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int LEN_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startPulse,
  input  logic                    dirRead,
  input  logic [ADDR_W-1:0]       startSector,
  input  logic [LEN_W-1:0]        sectorCount,
  input  logic [2:0]              patternSel,
  input  logic                    wrAlmostFull,
  output logic                    wrEn,
  output logic [31:0]             wrData,
  input  logic                    rdEmpty,
  input  logic [31:0]             rdData,
  output logic                    rdEn,
  output logic                    busy,
  output logic [LEN_W+6:0]        wordCount,
  output logic                    failFlag,
  output logic [ADDR_W+8:0]       failByteAddr,
  output logic [31:0]             failExpected,
  output logic [31:0]             failReceived
);
  spe_strobe_t       strb;
  logic [WORD_W-1:0] genWord;

  spe_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .dirRead(dirRead),
    .sectorCount(sectorCount), .wrAlmostFull(wrAlmostFull), .rdEmpty(rdEmpty),
    .wrEn(wrEn), .rdEn(rdEn), .busy(busy), .wordCount(wordCount), .strb(strb)
  );

  spe_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .startSector(startSector),
    .patternSel(patternSel), .rdData(rdData), .genWord(genWord),
    .failFlag(failFlag), .failByteAddr(failByteAddr),
    .failExpected(failExpected), .failReceived(failReceived)
  );

  assign wrData = genWord;
endmodule

// File: rtl/spe_checker.sv
module spe_checker #(
  parameter int LEN_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic             busy,
  input logic             wrEn,
  input logic             wrAlmostFull,
  input logic             rdEn,
  input logic             rdEmpty,
  input logic             failFlag,
  input logic [31:0]      failExpected,
  input logic [LEN_W+6:0] wordCount
);
  a_r2_wr_gated: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (busy && !wrAlmostFull));

  a_r4_rd_gated: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> (busy && !rdEmpty));

  a_r2_one_direction: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && rdEn));

  a_r1_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !wrEn && !rdEn) |=> busy);

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (wrEn || rdEn)) |=> (wordCount == $past(wordCount) + 1'b1));

  a_r10_count_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !wrEn && !rdEn) |=> $stable(wordCount));

  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !(startPulse && !busy)) |=> failFlag);

  a_r9_capture_held: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !(startPulse && !busy)) |=> $stable(failExpected));
endmodule

bind sector_pattern_engine spe_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .busy(busy),
  .wrEn(wrEn), .wrAlmostFull(wrAlmostFull), .rdEn(rdEn), .rdEmpty(rdEmpty),
  .failFlag(failFlag), .failExpected(failExpected), .wordCount(wordCount)
);

// File: tb/sim_sector_pattern_engine.sv
`timescale 1ns/1ps
module sim_sector_pattern_engine;
  localparam int ADDR_W = 48;
  localparam int LEN_W  = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startPulse = 1'b0;
  logic              dirRead = 1'b0;
  logic [ADDR_W-1:0] startSector = '0;
  logic [LEN_W-1:0]  sectorCount = '0;
  logic [2:0]        patternSel = '0;
  logic              wrAlmostFull = 1'b0;
  logic              wrEn;
  logic [31:0]       wrData;
  logic              rdEmpty = 1'b1;
  logic [31:0]       rdData = '0;
  logic              rdEn;
  logic              busy;
  logic [LEN_W+6:0]  wordCount;
  logic              failFlag;
  logic [ADDR_W+8:0] failByteAddr;
  logic [31:0]       failExpected;
  logic [31:0]       failReceived;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  always #2 clk = ~clk;

  sector_pattern_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u0 (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lfsrStep(input logic [31:0] q);
    return {q[30:0], q[30] ^ q[20] ^ q[0]};
  endfunction

  function automatic logic [31:0] modelWord(input logic [47:0] sec, input logic [6:0] idx,
                                            input logic [2:0] sel, input logic [31:0] lf);
    logic [31:0] inc;
    inc = {sec[24:0], idx};
    if (idx == 7'd0) return sec[31:0];
    if (idx == 7'd1) return {16'h0, sec[47:32]};
    case (sel)
      3'd0: return inc;
      3'd1: return ~inc;
      3'd3: return 32'hFFFF_FFFF;
      3'd4: return lf;
      default: return 32'h0;
    endcase
  endfunction

  // Runs one transfer and checks stream, enables, count and fail capture.
  // badA/badB: word numbers to corrupt on reads (-1 none); ignAt: word number
  // at which a start pulse is injected while busy (-1 none).
  task automatic runXfer(input bit rd, input logic [47:0] sec, input int n,
                         input logic [2:0] sel, input int badA, input int badB,
                         input int stall, input int ignAt, input string tag);
    logic [47:0] mSec = sec;
    logic [6:0]  mIdx = 0;
    logic [31:0] mLf  = sec[31:0];
    int total = n * 128;
    int k = 0;
    int enErr = 0, dataErr = 0, firstK = -1;
    logic [31:0] act0 = 0, exp0 = 0, e;
    logic [56:0] capAddr = 0;
    logic [31:0] capExp = 0, capRcv = 0;
    int guard = 0;

    @(negedge clk);
    dirRead = rd; startSector = sec; sectorCount = LEN_W'(n); patternSel = sel;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check(busy == 1'b1, {"R1 busy after start ", tag}, 64'(busy), 64'd1);
    while (k < total && guard < 20000) begin
      guard++;
      e = modelWord(mSec, mIdx, sel, mLf);
      if (rd) begin
        rdEmpty = ($urandom_range(99) < stall);
        rdData  = ((k == badA) || (k == badB)) ? (e ^ 32'h0000_0100) : e;
        wrAlmostFull = 1'b0;
      end else begin
        wrAlmostFull = ($urandom_range(99) < stall);
        rdEmpty = 1'b1;
      end
      // R10: start while busy, with different settings, must be ignored
      startPulse  = (k == ignAt);
      if (k == ignAt) begin
        startSector = 48'h1234; sectorCount = 1; patternSel = 3'd3; dirRead = ~rd;
      end
      #1;
      if (rd) begin
        if (rdEn !== !rdEmpty || wrEn !== 1'b0) enErr++;
        if (rdEn && rdData != e && capExp == 0 && capRcv == 0) begin
          capAddr = (57'(mSec) << 9) + 57'(mIdx) * 57'd4;
          capExp = e; capRcv = rdData;
        end
      end else begin
        if (wrEn !== !wrAlmostFull || rdEn !== 1'b0) enErr++;
        if (wrEn && wrData !== e) begin
          dataErr++;
          if (firstK < 0) begin firstK = k; act0 = wrData; exp0 = e; end
        end
      end
      if ((rd && rdEn) || (!rd && wrEn)) begin
        k++;
        if (mIdx == 7'd127) begin
          mSec = mSec + 1; mLf = mSec[31:0]; mIdx = 0;
        end else begin
          if (mIdx >= 7'd2) mLf = lfsrStep(mLf);
          mIdx = mIdx + 1;
        end
      end
      @(negedge clk);
      startPulse = 1'b0;
    end
    wrAlmostFull = 1'b0; rdEmpty = 1'b1;
    check(enErr == 0, {rd ? "R4 read enable rule " : "R2 write enable rule ", tag},
          64'(enErr), 64'd0);
    if (!rd)
      check(dataErr == 0, {"R5 R6 R7 R10 write stream ", tag}, 64'(act0), 64'(exp0));
    check(busy == 1'b0, {"R1 busy falls at end ", tag}, 64'(busy), 64'd0);
    check(wordCount == (LEN_W+7)'(total), {"R3 final word count ", tag},
          64'(wordCount), 64'(total));
    if (rd) begin
      check(failFlag == (badA >= 0), {"R8 fail flag ", tag}, 64'(failFlag), 64'(badA >= 0));
      if (badA >= 0) begin
        check(failByteAddr == capAddr, {"R9 fail byte address ", tag},
              64'(failByteAddr), 64'(capAddr));
        check(failExpected == capExp && failReceived == capRcv,
              {"R9 captured words ", tag}, {failExpected, failReceived}, {capExp, capRcv});
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0_FFEE));
    repeat (3) @(negedge clk);
    rdEmpty = 1'b0;
    #1;
    check(!busy && !wrEn && !rdEn && !failFlag && wordCount == 0, "R12 reset state",
          {59'd0, busy, wrEn, rdEn, failFlag, |wordCount}, 64'd0);
    rdEmpty = 1'b1;
    rstN = 1'b1;

    runXfer(0, 48'h0000_1000, 2, 3'd0, -1, -1, 30, -1, "inc");
    runXfer(0, 48'h00AB_5555_0003, 1, 3'd1, -1, -1, 10, -1, "dec");
    runXfer(0, 48'h7, 1, 3'd2, -1, -1, 0, -1, "zero");
    runXfer(0, 48'h8, 1, 3'd3, -1, -1, 20, -1, "ones");
    runXfer(0, 48'h0000_FFFF_FFFF, 2, 3'd4, -1, -1, 50, -1, "lfsr wrap R5");
    runXfer(0, 48'h42, 1, 3'd6, -1, -1, 15, -1, "code6");
    runXfer(0, 48'h9_0000_0011, 2, 3'd4, -1, -1, 25, 60, "ignored start R10");
    runXfer(1, 48'h3_1234_5678, 2, 3'd4, -1, -1, 40, -1, "read clean");
    runXfer(1, 48'h0000_2000, 2, 3'd0, 130, 140, 35, -1, "read bad");

    // R11: a zero-count start clears status and stays idle
    @(negedge clk);
    sectorCount = 0; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    #1;
    check(!busy && !failFlag && wordCount == 0 && failExpected == 0 &&
          failReceived == 0 && failByteAddr == 0, "R11 R1 zero-count start clears",
          {busy, failFlag, 30'd0, failExpected}, 64'd0);

    for (int t = 0; t < 4; t++) begin
      logic [47:0] s;
      s = {16'($urandom), $urandom};
      runXfer(t[0], s, 1 + int'($urandom_range(1)), 3'($urandom_range(4)), -1, -1,
              int'($urandom_range(60)), -1, "random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule